// File: doc/BRIEF.md
# Synchronous PCM Codec Serial Port

This block connects a parallel sample interface to a PCM codec over two three-wire serial links. The transmit link carries a shift clock, a frame sync and a data line, and so does the receive link. The two links run full duplex. They can run from unrelated clocks, or the receive side can follow the transmit clock and frame sync. Both shift clocks come from outside. The port samples them with the system clock `clk`, so each shift clock must run well below `clk`.

A frame starts when the frame sync is high at a falling edge of the shift clock. The most significant bit goes out on the next rising edge, and each later rising edge sends the next bit. The receive side takes one bit at each falling edge after the frame-sync edge. Samples are 8 or 13 bits wide and sit left-justified in 16-bit words on the parallel side. Each direction has one holding register with a valid/ready handshake. Underrun and overrun are reported by flags that stay set until reset.

Top module: `pcm_serial_port`

## Requirements
- R1: Transmit and receive run at the same time. A transmit frame and a receive frame in flight together do not disturb each other.
- R2: With `cfg_shared`=0, the receive side is timed only by `rx_sclk` and `rx_fsync`. These may run at a different rate from the transmit clock.
- R3: With `cfg_shared`=1, the receive side uses `tx_sclk` and `tx_fsync`, and `rx_sclk` and `rx_fsync` have no effect.
- R4: `cfg_wide`=0 selects 8-bit samples and `cfg_wide`=1 selects 13-bit samples. The width is taken when a transmit word is loaded and when a receive frame starts.
- R5: A frame starts when the frame sync is high at a falling shift-clock edge. The sample's MSB (word bit 15) is driven after the next rising edge, and the remaining bits follow in order down to the LSB.
- R6: `tx_sd` changes only after rising edges of the transmit shift clock, and `tx_sd` is 0 once the last sample bit has been sent. Receive bits are sampled on falling edges.
- R7: A transmit word is accepted when `tx_valid` and `tx_ready` are both high. `tx_ready` stays low until that word starts a frame. Only the top width bits of `tx_data` are sent.
- R8: If no word is held when a transmit frame starts, the frame sends all zeros and `tx_underrun` is set and stays set.
- R9: A received sample appears in `rx_data` bits 15 down, with the unused low bits zero. `rx_valid` and `rx_data` hold until `rx_ready` is seen high.
- R10: If a sample completes while the previous one is still unread, it overwrites that sample and `rx_overrun` is set and stays set.
- R11: After reset, `tx_ready`=1, `rx_valid`=0, `tx_sd`=0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shared | input | 1 | 1: receive side follows the transmit clock and frame sync |
| cfg_wide | input | 1 | Sample width: 0 = 8 bits, 1 = 13 bits |
| tx_sclk | input | 1 | Transmit shift clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_sd | output | 1 | Transmit serial data |
| rx_sclk | input | 1 | Receive shift clock (used when cfg_shared=0) |
| rx_fsync | input | 1 | Receive frame sync (used when cfg_shared=0) |
| rx_sd | input | 1 | Receive serial data |
| tx_data | input | 16 | Transmit sample, left-justified |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding register is empty |
| rx_data | output | 16 | Received sample, left-justified |
| rx_valid | output | 1 | Received sample available |
| rx_ready | input | 1 | Received sample is taken |
| tx_underrun | output | 1 | Sticky: a frame started with no word held |
| rx_overrun | output | 1 | Sticky: an unread sample was overwritten |

## Verification
The bench uses the default widths of 8 and 13 bits, so both sample formats go out and come in. It keeps the two-stage synchronizer. With that depth, a shift-clock half period of six or seven system clocks leaves the transmit data settled before the bench samples it. The transmit and receive clocks use different half periods, so frames on the two links overlap with different phases. That reaches the independent-clock case and the case where the receive side follows the transmit clock.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam int unsigned AP_WORD_W = 16;
  localparam int unsigned AP_PTR_W  = $clog2(AP_WORD_W);

  typedef logic [AP_WORD_W-1:0] word_t;
  typedef logic [AP_PTR_W-1:0]  ptr_t;

  // Sample width chosen by the width select.
  function automatic int unsigned sample_bits(logic wide, int unsigned nb, int unsigned wb);
    return wide ? wb : nb;
  endfunction

  // Keep the n most significant bits of a word and clear the rest.
  function automatic word_t keep_msbs(word_t w, int unsigned n);
    word_t m;
    m = ~({AP_WORD_W{1'b1}} >> n);
    return w & m;
  endfunction

  // Bit index that holds the last bit of an n-bit left-justified sample.
  function automatic ptr_t stop_index(int unsigned n);
    return ptr_t'(AP_WORD_W - n);
  endfunction

  // Write one bit into a word at the given position.
  function automatic word_t put_bit(word_t w, ptr_t p, logic b);
    word_t r;
    r    = w;
    r[p] = b;
    return r;
  endfunction
endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LANES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);
  logic [LANES-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/aud_edge_det.sv
module aud_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  if (RISING) begin : g_rise
    assign pulse = lvl & ~prev_q;
  end else begin : g_fall
    assign pulse = ~lvl & prev_q;
  end
endmodule

// File: rtl/aud_tx_path.sv
module aud_tx_path
  import aud_pkg::*;
#(
  parameter int unsigned NARROW_BITS = 8,
  parameter int unsigned WIDE_BITS   = 13
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wide,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  fsync,
  input  word_t tx_data,
  input  logic  tx_valid,
  output logic  tx_ready,
  output logic  tx_sd,
  output logic  underrun
);
  word_t hold_q, shift_q;
  logic  hold_full_q, pend_q, underrun_q;
  logic  accept, frame_start;
  int unsigned nbits_now;

  assign nbits_now   = sample_bits(wide, NARROW_BITS, WIDE_BITS);
  assign accept      = tx_valid & ~hold_full_q;
  assign frame_start = pend_q & sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      pend_q      <= 1'b0;
      shift_q     <= '0;
      underrun_q  <= 1'b0;
    end else begin
      if (sclk_fall && fsync)  pend_q <= 1'b1;
      else if (frame_start)    pend_q <= 1'b0;

      if (accept)              hold_q <= keep_msbs(tx_data, nbits_now);

      if (accept)              hold_full_q <= 1'b1;
      else if (frame_start)    hold_full_q <= 1'b0;

      if (frame_start) begin
        if (hold_full_q) begin
          shift_q <= hold_q;
        end else begin
          shift_q    <= '0;
          underrun_q <= 1'b1;
        end
      end else if (sclk_rise) begin
        shift_q <= {shift_q[AP_WORD_W-2:0], 1'b0};
      end
    end
  end

  assign tx_ready = ~hold_full_q;
  assign tx_sd    = shift_q[AP_WORD_W-1];
  assign underrun = underrun_q;

  AST_TX_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready && !frame_start |=> !tx_ready); // R7
  AST_TX_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !tx_ready |=> tx_sd == $past(hold_q[AP_WORD_W-1])); // R5
  AST_TX_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(tx_sd)); // R6
  AST_TX_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && tx_ready |=> underrun); // R8
  AST_TX_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun); // R8
endmodule

// File: rtl/aud_rx_path.sv
module aud_rx_path
  import aud_pkg::*;
#(
  parameter int unsigned NARROW_BITS = 8,
  parameter int unsigned WIDE_BITS   = 13
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wide,
  input  logic  sclk_fall,
  input  logic  fsync,
  input  logic  sd,
  output word_t rx_data,
  output logic  rx_valid,
  input  logic  rx_ready,
  output logic  overrun
);
  word_t acc_q, acc_next, data_q;
  ptr_t  ptr_q;
  logic  active_q, frame_wide_q, valid_q, overrun_q;
  logic  frame_begin, bit_evt, word_done;
  int unsigned nbits_frame;

  assign nbits_frame = sample_bits(frame_wide_q, NARROW_BITS, WIDE_BITS);
  assign frame_begin = sclk_fall & fsync;
  assign bit_evt     = sclk_fall & ~fsync & active_q;
  assign word_done   = bit_evt & (ptr_q == stop_index(nbits_frame));
  assign acc_next    = put_bit(acc_q, ptr_q, sd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      ptr_q        <= '0;
      active_q     <= 1'b0;
      frame_wide_q <= 1'b0;
      data_q       <= '0;
      valid_q      <= 1'b0;
      overrun_q    <= 1'b0;
    end else begin
      if (frame_begin) begin
        active_q     <= 1'b1;
        ptr_q        <= ptr_t'(AP_WORD_W - 1);
        acc_q        <= '0;
        frame_wide_q <= wide;
      end else if (bit_evt) begin
        acc_q <= acc_next;
        if (word_done) active_q <= 1'b0;
        else           ptr_q    <= ptr_q - ptr_t'(1);
      end

      if (word_done) begin
        data_q  <= acc_next;
        valid_q <= 1'b1;
        if (valid_q && !rx_ready) overrun_q <= 1'b1;
      end else if (valid_q && rx_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;
  assign overrun  = overrun_q;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !word_done |=> rx_valid && $stable(rx_data)); // R9
  AST_RX_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !frame_wide_q |=> rx_data[AP_WORD_W-NARROW_BITS-1:0] == '0); // R9
  AST_RX_WIDE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && frame_wide_q |=> rx_data[AP_WORD_W-WIDE_BITS-1:0] == '0); // R4
  AST_RX_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && rx_valid && !rx_ready |=> overrun); // R10
  AST_RX_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R10
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import aud_pkg::*;
#(
  parameter int unsigned NARROW_BITS = 8,
  parameter int unsigned WIDE_BITS   = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_shared,
  input  logic        cfg_wide,
  input  logic        tx_sclk,
  input  logic        tx_fsync,
  output logic        tx_sd,
  input  logic        rx_sclk,
  input  logic        rx_fsync,
  input  logic        rx_sd,
  input  logic [15:0] tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [15:0] rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        tx_underrun,
  output logic        rx_overrun
);
  localparam int unsigned TX_LANES = 2;
  localparam int unsigned RX_LANES = 3;

  logic [TX_LANES-1:0] tx_sync;
  logic [RX_LANES-1:0] rx_sync;
  logic tx_rise, tx_fall, rx_own_fall;
  logic rx_fall_sel, rx_fs_sel;

  aud_sync #(.STAGES(SYNC_STAGES), .LANES(TX_LANES)) u_tx_sync (
    .clk(clk), .rst_n(rst_n), .din({tx_fsync, tx_sclk}), .dout(tx_sync));

  aud_sync #(.STAGES(SYNC_STAGES), .LANES(RX_LANES)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .din({rx_sd, rx_fsync, rx_sclk}), .dout(rx_sync));

  aud_edge_det #(.RISING(1'b1)) u_tx_rise (
    .clk(clk), .rst_n(rst_n), .lvl(tx_sync[0]), .pulse(tx_rise));
  aud_edge_det #(.RISING(1'b0)) u_tx_fall (
    .clk(clk), .rst_n(rst_n), .lvl(tx_sync[0]), .pulse(tx_fall));
  aud_edge_det #(.RISING(1'b0)) u_rx_fall (
    .clk(clk), .rst_n(rst_n), .lvl(rx_sync[0]), .pulse(rx_own_fall));

  // Shared mode: receive timing follows the transmit clock and frame sync.
  assign rx_fall_sel = cfg_shared ? tx_fall    : rx_own_fall;
  assign rx_fs_sel   = cfg_shared ? tx_sync[1] : rx_sync[1];

  aud_tx_path #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide),
    .sclk_rise(tx_rise), .sclk_fall(tx_fall), .fsync(tx_sync[1]),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sd(tx_sd), .underrun(tx_underrun));

  aud_rx_path #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide),
    .sclk_fall(rx_fall_sel), .fsync(rx_fs_sel), .sd(rx_sync[2]),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .overrun(rx_overrun));

  AST_FLAGS_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tx_underrun && !rx_overrun); // R11
endmodule

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_shared = 1'b0, cfg_wide = 1'b0;
  logic        tx_sclk = 1'b0, tx_fsync = 1'b0, tx_sd;
  logic        rx_sclk = 1'b0, rx_fsync = 1'b0, rx_sd = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid, rx_ready = 1'b1;
  logic        tx_underrun, rx_overrun;

  int checks = 0, errors = 0, rx_got = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_serial_port i_pcm_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_shared(cfg_shared), .cfg_wide(cfg_wide),
    .tx_sclk(tx_sclk), .tx_fsync(tx_fsync), .tx_sd(tx_sd),
    .rx_sclk(rx_sclk), .rx_fsync(rx_fsync), .rx_sd(rx_sd),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun));

  function automatic logic [15:0] top_n(logic [15:0] w, int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[15-i] = w[15-i];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected receive words as the design hands them over.
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      rx_got++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected word", rx_data, 16'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R9 received word", rx_data, e);
      end
    end
  end

  task automatic tx_load(logic [15:0] w);
    @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R7 ready low while word held", 16'(tx_ready), 16'h0);
  endtask

  // Drives one transmit frame; optionally also feeds rx_sd for shared mode.
  task automatic tx_frame(logic [15:0] exp_w, int n, int half, bit with_rx, logic [15:0] rxw);
    logic [15:0] got = '0;
    bit tail_ok = 1'b1;
    if (with_rx) exp_q.push_back(top_n(rxw, n));
    tx_fsync = 1'b1; tx_sclk = 1'b1; wait_clk(half);
    tx_sclk = 1'b0; wait_clk(half);
    for (int k = 0; k < n + 2; k++) begin
      tx_sclk = 1'b1; tx_fsync = 1'b0;
      if (with_rx && k < n) rx_sd = rxw[15-k];
      wait_clk(half);
      if (k < n) got[15-k] = tx_sd;
      else if (tx_sd !== 1'b0) tail_ok = 1'b0;
      tx_sclk = 1'b0; wait_clk(half);
    end
    check(got == exp_w, "R5 R6 transmit bits MSB first", got, exp_w);
    check(tail_ok, "R6 line low after last bit", 16'(tail_ok), 16'h1);
  endtask

  task automatic rx_frame(logic [15:0] w, int n, int half, bit push);
    if (push) exp_q.push_back(top_n(w, n));
    rx_fsync = 1'b1; rx_sclk = 1'b1; wait_clk(half);
    rx_sclk = 1'b0; wait_clk(half);
    for (int k = 0; k < n; k++) begin
      rx_sclk = 1'b1; rx_fsync = 1'b0; rx_sd = w[15-k];
      wait_clk(half);
      rx_sclk = 1'b0; wait_clk(half);
    end
    wait_clk(2 * half);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int got_before;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R11 reset state
    check(tx_ready == 1'b1, "R11 tx_ready after reset", 16'(tx_ready), 16'h1);
    check(rx_valid == 1'b0, "R11 rx_valid after reset", 16'(rx_valid), 16'h0);
    check(tx_sd == 1'b0 && !tx_underrun && !rx_overrun, "R11 line and flags",
          {13'h0, tx_sd, tx_underrun, rx_overrun}, 16'h0);

    // R8 underrun: frame with nothing loaded sends zeros
    tx_frame(16'h0000, 8, 6, 1'b0, 16'h0);
    check(tx_underrun == 1'b1, "R8 underrun flag", 16'(tx_underrun), 16'h1);

    // R7 load then send 8-bit sample, low byte ignored
    tx_load(16'hA5C3);
    tx_frame(16'hA500, 8, 6, 1'b0, 16'h0);
    check(tx_ready == 1'b1, "R7 ready after frame", 16'(tx_ready), 16'h1);

    // R1 R2 full duplex on unrelated clocks
    tx_load(16'h3C7E);
    fork
      tx_frame(16'h3C00, 8, 6, 1'b0, 16'h0);
      rx_frame(16'h9E41, 8, 7, 1'b1);
    join
    wait_clk(4);
    check(rx_got == 1, "R1 R2 one word received", 16'(rx_got), 16'h1);

    // R4 13-bit samples on both paths
    cfg_wide = 1'b1;
    tx_load(16'hFFFF);
    fork
      tx_frame(16'hFFF8, 13, 6, 1'b0, 16'h0);
      rx_frame(16'hB6D5, 13, 7, 1'b1);
    join
    wait_clk(4);
    check(rx_got == 2, "R4 wide word received", 16'(rx_got), 16'h2);

    // R3 shared mode: rx pins held idle, rx follows transmit timing
    cfg_shared = 1'b1;
    rx_sclk = 1'b0; rx_fsync = 1'b0;
    got_before = rx_got;
    tx_load(16'h5A5A);
    tx_frame(16'h5A58, 13, 6, 1'b1, 16'h1234);
    wait_clk(4);
    check(rx_got == got_before + 1, "R3 shared-clock receive", 16'(rx_got), 16'(got_before + 1));

    // R10 overrun, R9 hold while not ready
    cfg_shared = 1'b0; cfg_wide = 1'b0;
    rx_ready = 1'b0;
    rx_frame(16'h11FF, 8, 7, 1'b0);
    wait_clk(10);
    check(rx_valid == 1'b1 && rx_data == 16'h1100, "R9 word held unread", rx_data, 16'h1100);
    check(rx_overrun == 1'b0, "R10 no overrun yet", 16'(rx_overrun), 16'h0);
    rx_frame(16'h2200, 8, 7, 1'b1);
    check(rx_overrun == 1'b1, "R10 overrun flag", 16'(rx_overrun), 16'h1);
    check(rx_data == 16'h2200, "R10 old word overwritten", rx_data, 16'h2200);
    rx_ready = 1'b1;
    wait_clk(4);
    check(rx_valid == 1'b0, "R9 valid drops after read", 16'(rx_valid), 16'h0);
    check(tx_underrun == 1'b1 && rx_overrun == 1'b1, "R8 R10 flags stay set",
          {14'h0, tx_underrun, rx_overrun}, 16'h3);
    check(exp_q.size() == 0, "R9 all expected words seen", 16'(exp_q.size()), 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule